// File: doc/BRIEF.md
# Exception State Capture and PC Steering

This block sits in the datapath of a multicycle processor. It chooses the next program counter value from four sources: the live ALU result, the registered ALU output, a jump target built from the instruction's index field, and a single fixed handler entry address. It also holds the program counter register. A write strobe loads that register without condition, and a second strobe loads it only when the ALU reports a zero result.

Next to the PC steering, the block keeps the state that an exception leaves behind. The exception PC register takes the ALU result on its own strobe. The controller arranges for that result to be the current PC minus four, which is the address of the faulting instruction. The cause register takes a one-bit code on its own strobe: code 0 means an undefined opcode and code 1 means an arithmetic overflow. The ALU overflow flag is registered every cycle, so the controller can test it in the cycle after the execute step.

The controller decides when an exception happens. This block only captures the state and redirects the PC when the controller tells it to.

Top module: `exc_capture_unit`

## Requirements
- R1: While rst_n is low, pc_q, epc_q, cause_q and ovf_held are all zero.
- R2: next_pc equals alu_result when pc_src is 0, and equals alu_out_reg when pc_src is 1.
- R3: When pc_src is 2, next_pc equals {pc_q[31:28], instr_idx[25:0], 2'b00}.
- R4: When pc_src is 3, next_pc equals the handler address 32'h8000_0180.
- R5: On a rising clock edge with pc_wr high, pc_q takes the value of next_pc.
- R6: With pc_wr low and pc_wr_cond high, pc_q takes next_pc only if alu_zero is 1; if alu_zero is 0, pc_q keeps its value.
- R7: On an edge with epc_wr high, epc_q takes alu_result. With epc_wr low, epc_q keeps its value.
- R8: On an edge with cause_wr high, cause_q takes {31'b0, cause_sel}, where cause_sel 0 means an undefined instruction and 1 means overflow. With cause_wr low, cause_q keeps its value. Bits [31:1] are always zero.
- R9: After each rising edge, ovf_held equals the value alu_ovf had just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_result | input | 32 | Combinational ALU result |
| alu_out_reg | input | 32 | Registered ALU output |
| instr_idx | input | 26 | Index field of the jump instruction |
| pc_src | input | 2 | Next-PC source select (0 ALU, 1 ALU register, 2 jump, 3 handler) |
| pc_wr | input | 1 | Unconditional PC write strobe |
| pc_wr_cond | input | 1 | PC write strobe gated by alu_zero |
| alu_zero | input | 1 | ALU zero flag |
| alu_ovf | input | 1 | ALU overflow flag |
| epc_wr | input | 1 | Exception PC write strobe |
| cause_wr | input | 1 | Cause register write strobe |
| cause_sel | input | 1 | Cause code (0 undefined opcode, 1 overflow) |
| next_pc | output | 32 | Selected next PC value |
| pc_q | output | 32 | Program counter register |
| epc_q | output | 32 | Saved exception PC |
| cause_q | output | 32 | Saved exception cause |
| ovf_held | output | 1 | Overflow flag from the previous cycle |

## Verification
If a strobe is decoded wrongly, the error appears on pc_q, epc_q or cause_q one edge after the faulty write. It also shows up when a register changes in a cycle with no strobe at all. The jump path depends on the PC's top nibble, so a wrong pc_q also changes next_pc in the same cycle once pc_src is 2. A lost or inverted overflow flag shows on ovf_held one edge after the cycle in which alu_ovf was driven.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN  = 32;
  localparam int IDX_W = 26;
  localparam logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0180;

  typedef enum logic [1:0] {
    PCS_ALU     = 2'd0,
    PCS_ALUREG  = 2'd1,
    PCS_JUMP    = 2'd2,
    PCS_HANDLER = 2'd3
  } pc_src_e;

  localparam logic CAUSE_UNDEF = 1'b0;
  localparam logic CAUSE_OVF   = 1'b1;
endpackage

// File: rtl/exc_pc_steer.sv
module exc_pc_steer
  import exc_pkg::*;
#(
  parameter int W = XLEN,
  parameter int IW = IDX_W,
  parameter logic [W-1:0] HANDLER = HANDLER_ADDR
) (
  input  logic [W-1:0]  alu_result,
  input  logic [W-1:0]  alu_out_reg,
  input  logic [W-1:0]  pc_cur,
  input  logic [IW-1:0] idx,
  input  logic [1:0]    sel,
  output logic [W-1:0]  pc_nxt
);
  localparam int HI_W = W - IW - 2;

  logic [W-1:0] jump_tgt;

  always_comb begin
    jump_tgt = {pc_cur[W-1 -: HI_W], idx, 2'b00};
  end

  always_comb begin
    unique case (pc_src_e'(sel))
      PCS_ALU:     pc_nxt = alu_result;
      PCS_ALUREG:  pc_nxt = alu_out_reg;
      PCS_JUMP:    pc_nxt = jump_tgt;
      PCS_HANDLER: pc_nxt = HANDLER;
      default:     pc_nxt = alu_result;
    endcase
  end

  // R3
  always_comb begin
    jump_low_chk: assert (sel != 2'd2 || pc_nxt[1:0] == 2'b00)
      else $error("jump target not word aligned");
  end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] epc_in,
  input  logic         epc_wr,
  input  logic         cause_wr,
  input  logic         cause_sel,
  input  logic         ovf_in,
  output logic [W-1:0] epc_q,
  output logic [W-1:0] cause_q,
  output logic         ovf_q
);
  logic [W-1:0] epc_d;
  logic [W-1:0] cause_d;

  always_comb begin
    epc_d = epc_q;
    if (epc_wr) epc_d = epc_in;
  end

  always_comb begin
    cause_d = cause_q;
    if (cause_wr) cause_d = {{(W-1){1'b0}}, cause_sel};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q   <= '0;
      cause_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      epc_q   <= epc_d;
      cause_q <= cause_d;
      ovf_q   <= ovf_in;
    end
  end

  // R7
  epc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epc_wr |=> epc_q == $past(epc_in));
  // R7
  epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !epc_wr |=> $stable(epc_q));
  // R8
  cause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_wr |=> cause_q[0] == $past(cause_sel));
  // R8
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_wr |=> $stable(cause_q));
  // R8
  cause_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q[W-1:1] == '0);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ovf_q == $past(ovf_in));
endmodule

// File: rtl/exc_capture_unit.sv
module exc_capture_unit
  import exc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XLEN-1:0]  alu_result,
  input  logic [XLEN-1:0]  alu_out_reg,
  input  logic [IDX_W-1:0] instr_idx,
  input  logic [1:0]       pc_src,
  input  logic             pc_wr,
  input  logic             pc_wr_cond,
  input  logic             alu_zero,
  input  logic             alu_ovf,
  input  logic             epc_wr,
  input  logic             cause_wr,
  input  logic             cause_sel,
  output logic [XLEN-1:0]  next_pc,
  output logic [XLEN-1:0]  pc_q,
  output logic [XLEN-1:0]  epc_q,
  output logic [XLEN-1:0]  cause_q,
  output logic             ovf_held
);
  logic            pc_en;
  logic [XLEN-1:0] pc_d;

  exc_pc_steer #(.W(XLEN), .IW(IDX_W), .HANDLER(HANDLER_ADDR)) u_steer (
    .alu_result  (alu_result),
    .alu_out_reg (alu_out_reg),
    .pc_cur      (pc_q),
    .idx         (instr_idx),
    .sel         (pc_src),
    .pc_nxt      (next_pc)
  );

  exc_state_regs #(.W(XLEN)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .epc_in    (alu_result),
    .epc_wr    (epc_wr),
    .cause_wr  (cause_wr),
    .cause_sel (cause_sel),
    .ovf_in    (alu_ovf),
    .epc_q     (epc_q),
    .cause_q   (cause_q),
    .ovf_q     (ovf_held)
  );

  always_comb begin
    pc_en = pc_wr | (pc_wr_cond & alu_zero);
    pc_d  = pc_en ? next_pc : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R5
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr |=> pc_q == $past(next_pc));
  // R6
  pc_cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_wr && !(pc_wr_cond && alu_zero)) |=> $stable(pc_q));
  // R4
  handler_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_src == 2'd3 |-> next_pc == HANDLER_ADDR);
endmodule

// File: tb/exc_capture_unit_bench.sv
module exc_capture_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] alu_result, alu_out_reg;
  logic [25:0] instr_idx;
  logic [1:0]  pc_src;
  logic        pc_wr, pc_wr_cond, alu_zero, alu_ovf, epc_wr, cause_wr, cause_sel;
  logic [31:0] next_pc, pc_q, epc_q, cause_q;
  logic        ovf_held;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_pc, m_epc, m_cause;
  logic        m_ovf;

  string       q_tag[$];
  logic [31:0] q_pc[$], q_epc[$], q_cause[$];
  logic        q_ovf[$];

  always #4 clk = ~clk;

  exc_capture_unit u_exc_capture_unit (
    .clk(clk), .rst_n(rst_n), .alu_result(alu_result), .alu_out_reg(alu_out_reg),
    .instr_idx(instr_idx), .pc_src(pc_src), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
    .alu_zero(alu_zero), .alu_ovf(alu_ovf), .epc_wr(epc_wr), .cause_wr(cause_wr),
    .cause_sel(cause_sel), .next_pc(next_pc), .pc_q(pc_q), .epc_q(epc_q),
    .cause_q(cause_q), .ovf_held(ovf_held)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_next(logic [1:0] s, logic [31:0] ar,
                                           logic [31:0] ag, logic [25:0] ix);
    case (s)
      2'd0: return ar;
      2'd1: return ag;
      2'd2: return {m_pc[31:28], ix, 2'b00};
      default: return 32'h8000_0180;
    endcase
  endfunction

  // Driver: apply one cycle of stimulus, check next_pc, push expected state
  task automatic step(string tag, logic [1:0] s, logic pw, logic pwc, logic z,
                      logic ov, logic ew, logic cw, logic cs,
                      logic [31:0] ar, logic [31:0] ag, logic [25:0] ix);
    logic [31:0] np;
    @(negedge clk);
    pc_src = s; pc_wr = pw; pc_wr_cond = pwc; alu_zero = z; alu_ovf = ov;
    epc_wr = ew; cause_wr = cw; cause_sel = cs;
    alu_result = ar; alu_out_reg = ag; instr_idx = ix;
    np = exp_next(s, ar, ag, ix);
    #1;
    check({tag, " next_pc"}, next_pc, np);
    if (pw || (pwc && z)) m_pc = np;
    if (ew) m_epc = ar;
    if (cw) m_cause = {31'b0, cs};
    m_ovf = ov;
    q_tag.push_back(tag); q_pc.push_back(m_pc); q_epc.push_back(m_epc);
    q_cause.push_back(m_cause); q_ovf.push_back(m_ovf);
  endtask

  // Monitor: compare registered state after each edge
  always @(posedge clk) begin
    if (q_tag.size() > 0) begin
      string t;
      #1;
      t = q_tag.pop_front();
      check({t, " pc_q"}, pc_q, q_pc.pop_front());
      check({t, " epc_q"}, epc_q, q_epc.pop_front());
      check({t, " cause_q"}, cause_q, q_cause.pop_front());
      check({t, " ovf_held"}, {31'b0, ovf_held}, {31'b0, q_ovf.pop_front()});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pc_src = 0; pc_wr = 0; pc_wr_cond = 0; alu_zero = 0; alu_ovf = 0;
    epc_wr = 0; cause_wr = 0; cause_sel = 0;
    alu_result = 32'hFFFF_FFFF; alu_out_reg = 32'hFFFF_FFFF; instr_idx = '1;
    m_pc = 0; m_epc = 0; m_cause = 0; m_ovf = 0;
    epc_wr = 1; cause_wr = 1; cause_sel = 1; alu_ovf = 1; pc_wr = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values hold even with strobes asserted
    check("R1 pc_q", pc_q, 0);
    check("R1 epc_q", epc_q, 0);
    check("R1 cause_q", cause_q, 0);
    check("R1 ovf_held", {31'b0, ovf_held}, 0);
    @(negedge clk);
    epc_wr = 0; cause_wr = 0; cause_sel = 0; alu_ovf = 0; pc_wr = 0;
    rst_n = 1'b1;

    step("R2 R5 alu src", 2'd0, 1, 0, 0, 0, 0, 0, 0, 32'h0000_0100, 32'h1, 26'h0);
    step("R2 R5 alureg src", 2'd1, 1, 0, 0, 0, 0, 0, 0, 32'h5, 32'h0000_0200, 26'h0);
    step("R6 cond no zero", 2'd0, 0, 1, 0, 0, 0, 0, 0, 32'h0000_0999, 32'h0, 26'h0);
    step("R6 cond zero", 2'd0, 0, 1, 1, 0, 0, 0, 0, 32'h0000_0300, 32'h0, 26'h0);
    step("R5 hold no strobe", 2'd1, 0, 0, 1, 0, 0, 0, 0, 32'h7, 32'h0000_0444, 26'h0);
    step("R3 jump max idx", 2'd2, 1, 0, 0, 0, 0, 0, 0, 32'h0, 32'h0, 26'h3FF_FFFF);
    step("R5 set high pc", 2'd0, 1, 0, 0, 0, 0, 0, 0, 32'hA000_0000, 32'h0, 26'h0);
    step("R3 jump keeps nibble", 2'd2, 1, 0, 0, 0, 0, 0, 0, 32'h0, 32'h0, 26'h000_0123);
    step("R7 R8 undef capture", 2'd0, 0, 0, 0, 0, 1, 1, 0, 32'hA000_0488, 32'h0, 26'h0);
    step("R9 ovf raise", 2'd0, 0, 0, 0, 1, 0, 0, 0, 32'h1234_5678, 32'h0, 26'h0);
    step("R7 R8 R4 ovf capture", 2'd3, 1, 0, 0, 0, 1, 1, 1, 32'hA000_048C, 32'h0, 26'h0);
    step("R7 R8 hold", 2'd1, 0, 0, 0, 1, 0, 0, 0, 32'hDEAD_BEEF, 32'hCAFE_F00D, 26'h155_5555);
    step("R9 ovf drop", 2'd3, 0, 0, 0, 0, 0, 0, 1, 32'h0BAD_0BAD, 32'h0, 26'h0);
    step("R8 cause back to undef", 2'd2, 0, 1, 0, 0, 0, 1, 0, 32'h0, 32'h0, 26'h2AA_AAAA);
    step("R4 R6 handler on zero", 2'd3, 0, 1, 1, 1, 0, 0, 0, 32'h0, 32'h0, 26'h0);
    step("R7 epc second load", 2'd0, 0, 0, 0, 0, 1, 0, 1, 32'h8000_017C, 32'h0, 26'h0);
    @(negedge clk);
    epc_wr = 0; cause_wr = 0; pc_wr = 0; pc_wr_cond = 0;
    repeat (2) @(posedge clk);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule